// File: doc/BRIEF.md
# Single-Item Coin Credit Controller

This block is the control core of a vending machine that sells one item priced at 30 units. Two coin pulse inputs report a 10-unit coin and a 20-unit coin, each high for one clock cycle per coin. The controller keeps the credit inserted so far and raises a vend output when that credit reaches the price.

The credit is stored as one of four levels: 0, 10, 20, or "30 or more". The level is held in a 2-bit register that loads on each rising clock edge. The vend output depends only on that register: it is high while the credit level is "30 or more". One cycle later the level returns to zero. Any credit above 30 is lost, because the block never gives change.

A coin that arrives during the vend cycle is counted from zero credit. If both coin pulses are high in the same cycle, the block treats it as a faulty reading and ignores it.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, the credit is cleared to zero and vend_o is 0 at once, without waiting for a clock edge. After release, a full 30 units must be inserted before vend_o rises again.
- R2: In a cycle with neither coin input high, a credit of 0, 10 or 20 is kept unchanged, and vend_o stays 0.
- R3: A cycle with only coin10_i high adds 10 units to the credit.
- R4: A cycle with only coin20_i high adds 20 units to the credit.
- R5: vend_o rises in the cycle that follows the edge at which the credit reaches exactly 30, by the sequences 10+20, 20+10 or 10+10+10.
- R6: A 20-unit coin inserted at a credit of 20 also raises vend_o. The extra 10 units are lost: after that vend, two 10-unit coins do not raise vend_o again.
- R7: vend_o is high for exactly one cycle per sale. If no coin arrives during that cycle, the credit afterwards is zero.
- R8: A coin that arrives during the vend cycle is counted from zero. A 10-unit coin leaves a credit of 10, and a 20-unit coin leaves a credit of 20; neither raises vend_o in the next cycle.
- R9: A cycle with coin10_i and coin20_i both high adds no credit. The credit stays as it was, or drops to zero if that cycle was the vend cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the credit register loads on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin10_i | input | 1 | One-cycle pulse for each 10-unit coin |
| coin20_i | input | 1 | One-cycle pulse for each 20-unit coin |
| vend_o | output | 1 | High for one cycle when a sale is made |

## Verification
The credit level cannot be read at the ports. Credit held by the block is therefore only shown by what a later coin does. The bench follows each idle or invalid cycle with the coin that completes the price, so the vend appears only if the credit was kept.

The hardest cases involve the vend cycle itself: a coin arriving in the very cycle vend_o is high, and a double-coin pulse landing there. The vector table places 10-unit, 20-unit and double pulses directly on that cycle, then adds further coins to show the credit that followed.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned CREDIT_W = 2;

  typedef enum logic [CREDIT_W-1:0] {
    CR_ZERO   = 2'b00,
    CR_TEN    = 2'b01,
    CR_TWENTY = 2'b10,
    CR_FULL   = 2'b11
  } credit_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'b00,
    EV_TEN    = 2'b01,
    EV_TWENTY = 2'b10,
    EV_BAD    = 2'b11
  } coin_ev_e;
endpackage

// File: rtl/coin_classify.sv
module coin_classify
  import vend_pkg::*;
(
  input  logic     coin10_i,
  input  logic     coin20_i,
  output coin_ev_e ev_o
);
  always_comb begin
    unique case ({coin20_i, coin10_i})
      2'b01:   ev_o = EV_TEN;
      2'b10:   ev_o = EV_TWENTY;
      2'b11:   ev_o = EV_BAD;
      default: ev_o = EV_NONE;
    endcase
  end
endmodule

// File: rtl/credit_step.sv
module credit_step
  import vend_pkg::*;
(
  input  credit_e  cur_i,
  input  coin_ev_e ev_i,
  output credit_e  nxt_o
);
  credit_e base;

  // the vend state is left after one cycle; its coin counts from zero
  assign base = (cur_i == CR_FULL) ? CR_ZERO : cur_i;

  always_comb begin
    nxt_o = base;
    unique case (ev_i)
      EV_TEN: begin
        unique case (base)
          CR_ZERO:   nxt_o = CR_TEN;
          CR_TEN:    nxt_o = CR_TWENTY;
          default:   nxt_o = CR_FULL;
        endcase
      end
      EV_TWENTY: begin
        // saturates: surplus above the price is forfeited
        nxt_o = (base == CR_ZERO) ? CR_TWENTY : CR_FULL;
      end
      default: nxt_o = base;
    endcase
  end
endmodule

// File: rtl/credit_reg.sv
module credit_reg
  import vend_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  credit_e d_i,
  output credit_e q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= CR_ZERO;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coin10_i,
  input  logic coin20_i,
  output logic vend_o
);
  coin_ev_e ev;
  credit_e  state_d;
  credit_e  state_q;

  coin_classify u_classify (
    .coin10_i (coin10_i),
    .coin20_i (coin20_i),
    .ev_o     (ev)
  );

  credit_step u_step (
    .cur_i (state_q),
    .ev_i  (ev),
    .nxt_o (state_d)
  );

  credit_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  assign vend_o = (state_q == CR_FULL);
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       coin10_i,
  input logic       coin20_i,
  input logic       vend_o,
  input logic [1:0] state_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (state_q == 2'b00 && !vend_o); // R1
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!coin10_i && !coin20_i && state_q != 2'b11) |=> (state_q == $past(state_q) && !vend_o)); // R2

  AST_TEN_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin10_i && !coin20_i && state_q == 2'b00) |=> state_q == 2'b01); // R3

  AST_TWENTY_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin20_i && !coin10_i && state_q == 2'b01) |=> vend_o); // R4

  AST_TEN_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin10_i && !coin20_i && state_q == 2'b10) |=> vend_o); // R5

  AST_OVERPAY_VENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin20_i && !coin10_i && state_q == 2'b10) |=> vend_o); // R6

  AST_VEND_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vend_o |=> !vend_o); // R7

  AST_VEND_COIN_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vend_o && coin10_i && !coin20_i) |=> state_q == 2'b01); // R8

  AST_DOUBLE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin10_i && coin20_i && state_q != 2'b11) |=> state_q == $past(state_q)); // R9
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .coin10_i (coin10_i),
  .coin20_i (coin20_i),
  .vend_o   (vend_o),
  .state_q  (state_q)
);

// File: tb/vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module vend_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c10 = 1'b0;
  logic c20 = 1'b0;
  logic vend;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2 clk = ~clk;

  vend_ctrl dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .coin10_i (c10),
    .coin20_i (c20),
    .vend_o   (vend)
  );

  // {coin10, coin20, expected vend after the edge}, applied back to back
  localparam int NV = 30;
  localparam logic [2:0] VEC [NV] = '{
    3'b100, // R3 credit 10
    3'b000, // R2 hold 10
    3'b011, // R4 R5 10+20 vends
    3'b000, // R7 back to zero
    3'b010, // R4 credit 20
    3'b000, // R2 hold 20
    3'b101, // R5 20+10 vends
    3'b000, // R7
    3'b100, // R3
    3'b100, // R3
    3'b101, // R5 10+10+10 vends
    3'b000, // R7
    3'b010, // R4
    3'b011, // R6 20+20 vends
    3'b000, // R6 surplus dropped
    3'b100, // R6 credit 10 only
    3'b100, // R6 credit 20, no vend
    3'b101, // R5
    3'b110, // R9 double in vend cycle: to zero
    3'b100, // R9 credit 10 (proves zero)
    3'b110, // R9 ignored at 10
    3'b110, // R9 ignored at 10
    3'b011, // R9 10 kept, 20 completes
    3'b100, // R8 coin during vend -> 10
    3'b011, // R8 10+20 vends
    3'b010, // R8 coin during vend -> 20
    3'b000, // R2 hold 20
    3'b101, // R8 20 was kept
    3'b000, // R7
    3'b110  // R9 double at zero
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: vend_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    c10 = a;
    c20 = b;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1;
    check("R1 in reset", vend, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][2], VEC[i][1]);
      check($sformatf("vector %0d", i), vend, VEC[i][0]);
    end

    // R1: reset clears held credit
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset from 20", vend, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0);
    check("R1 credit lost", vend, 1'b0);
    step(1'b0, 1'b1);
    check("R1 fresh 10+20", vend, 1'b1);

    // R1: asynchronous drop of vend_o mid-cycle
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", vend, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check("R2 idle after reset", vend, 1'b0);

    finish_run();
  end

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: vend_o=%b expected run end", vend);
    finish_run();
  end
endmodule